// File: doc/BRIEF.md
# Real-Time Clock Register Engine with Read Snapshot

This block is the byte-level core of a real-time clock that sits behind a two-wire serial bus. A bus front end, not part of this block, turns the wire traffic into single-cycle events: a start for a write transfer, a start for a read transfer, a received byte, and a request for the next byte to send. The block keeps a 64-location register space. Locations 0 to 6 present the time and date in BCD. Location 7 is a control slot that holds nothing. Locations 8 to 63 are general-purpose RAM.

A counter driven by a one-pulse-per-second tick keeps the time running. Reads never see the live counters. Every start event, and every wrap of the auto-incrementing pointer from 0x3F to 0, freezes a BCD copy of the time. The bytes of one transfer therefore agree with each other even when a tick lands in the middle. Writes to the time locations reload the running fields. A byte read is returned on `rd_data` with `rd_valid` one cycle after `rd_req`.

Top module: `rtc_regfile`

## Requirements
- R1: The register pointer is 6 bits wide. Advancing it from 0x3F gives 0.
- R2: The first byte received after `start_wr` is loaded into the pointer, with bits 7:6 dropped. It is not stored anywhere. A `start_rd` leaves the pointer unchanged.
- R3: Each data byte written and each byte read advances the pointer by one. A `rd_req` returns the byte at the pointer on `rd_data` with `rd_valid` high in the following cycle. A start event in the same cycle takes precedence over a byte event, and a received byte takes precedence over `rd_req`.
- R4: Either start event copies the running time into locations 0 to 6. The layout is: 0 seconds, 1 minutes, 2 hours, 3 weekday (1 to 7), 4 date, 5 month (1 to 12), 6 year (00 to 99 since 2000), all in BCD. Reads return this copy and not the live time.
- R5: When the pointer wraps from 0x3F to 0 on a read or on a data write, the running time is copied into locations 0 to 6 again.
- R6: A data byte written to locations 0 to 6 reloads that field of the running time. Before BCD decoding, seconds and minutes keep bits 6:0, the date keeps bits 5:0, the month keeps bits 4:0 and the weekday keeps bits 2:0. A tick in the same cycle is dropped.
- R7: A write to location 7 has no effect, and location 7 always reads 0x00.
- R8: Locations 8 to 63 store written bytes and read them back. After reset, every one of them reads 0x00.
- R9: Hours byte: bit 6 set selects 12-hour format, with bit 5 set for PM and bits 4:0 holding 1 to 12 in BCD. Bit 6 clear selects 24-hour format, with 0 to 23 in BCD. Midnight is hour 12 AM and noon is hour 12 PM. The format of the last hours byte written decides the format of every later snapshot.
- R10: Each tick advances the seconds. The carry runs from seconds to minutes to hours, then to date and weekday together, then to month and year. Month lengths are correct, and February has 29 days when the year is divisible by 4. The weekday wraps from 7 to 1, and the year wraps from 99 to 0.
- R11: After reset, the pointer is 0, the time is 00:00:00 in 24-hour format, the weekday is 1, the date is 01/01/00, and the snapshot holds that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| start_wr | input | 1 | Start of a write transfer |
| start_rd | input | 1 | Start of a read transfer |
| wr_valid | input | 1 | A byte was received from the bus |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to send |
| rd_data | output | 8 | Byte read, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds the requested byte |

## Verification
A pointer that drifts by one shows up on the very next read: every later byte in the transfer comes from the neighbouring location, and a wrap recapture arrives one byte early or late. A snapshot captured at the wrong moment, or one that follows the live counters, shows up as a seconds byte that differs from the value at the last start, once the bench has ticked between capture and read. A wrong carry or month length stays hidden until the time crosses that boundary. The bench therefore loads times just short of the minute, day, month-end, leap-day and year-end boundaries and reads them back after a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    logic [7:0] r;
    r = ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    return r[6:0];
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [ADDR_W-1:0] ptr,
  output logic              data_wr,
  output logic              data_rd,
  output logic              wrap
);

  logic addr_phase;
  logic any_start;

  assign any_start = start_wr | start_rd;
  assign data_wr   = wr_valid & ~addr_phase & ~any_start;
  assign data_rd   = rd_req & ~wr_valid & ~any_start;
  assign wrap      = (data_wr | data_rd) & (ptr == {ADDR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      addr_phase <= 1'b0;
    end else if (start_wr) begin
      addr_phase <= 1'b1;
    end else if (start_rd) begin
      addr_phase <= 1'b0;
    end else if (wr_valid && addr_phase) begin
      ptr        <= wr_data[ADDR_W-1:0];
      addr_phase <= 1'b0;
    end else if (data_wr || data_rd) begin
      ptr <= ptr + 1'b1;
    end
  end

  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    ((data_wr || data_rd) && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));

  assert_addr_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && addr_phase && !any_start) |=> (ptr == $past(wr_data[ADDR_W-1:0]) && !addr_phase));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (data_wr || data_rd) |=> (ptr == $past(ptr) + 1'b1));

  assert_rd_keeps_ptr_R2: assert property (@(posedge clk) disable iff (rst)
    (start_rd && !start_wr) |=> $stable(ptr));

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ld_en,
  input  logic [2:0] ld_idx,
  input  logic [7:0] ld_byte,
  output rtc_time_t  now,
  output logic       h12
);

  rtc_time_t  nxt;
  logic [4:0] dim;
  logic [7:0] masked;
  logic [6:0] dec;
  logic [6:0] h12raw;
  logic [6:0] h24raw;
  logic [4:0] hr_dec;

  assign dim = month_days(now.mon, now.year);

  always_comb begin
    nxt = now;
    if (now.sec >= 6'd59) begin
      nxt.sec = '0;
      if (now.min >= 6'd59) begin
        nxt.min = '0;
        if (now.hour >= 5'd23) begin
          nxt.hour = '0;
          nxt.wday = (now.wday >= 3'd7) ? 3'd1 : now.wday + 3'd1;
          if (now.date >= dim) begin
            nxt.date = 5'd1;
            if (now.mon >= 4'd12) begin
              nxt.mon  = 4'd1;
              nxt.year = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
            end else begin
              nxt.mon = now.mon + 4'd1;
            end
          end else begin
            nxt.date = now.date + 5'd1;
          end
        end else begin
          nxt.hour = now.hour + 5'd1;
        end
      end else begin
        nxt.min = now.min + 6'd1;
      end
    end else begin
      nxt.sec = now.sec + 6'd1;
    end
  end

  always_comb begin
    case (ld_idx)
      3'd0, 3'd1: masked = {1'b0, ld_byte[6:0]};
      3'd3:       masked = {5'b0, ld_byte[2:0]};
      3'd4:       masked = {2'b0, ld_byte[5:0]};
      3'd5:       masked = {3'b0, ld_byte[4:0]};
      default:    masked = ld_byte;
    endcase
    dec    = bcd2bin(masked);
    h12raw = bcd2bin({3'b0, ld_byte[4:0]});
    h24raw = bcd2bin({2'b0, ld_byte[5:0]});
    if (ld_byte[6]) begin
      hr_dec = (h12raw == 7'd12) ? 5'd0 : h12raw[4:0];
      if (ld_byte[5]) hr_dec = hr_dec + 5'd12;
    end else begin
      hr_dec = h24raw[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '{year: 7'd0, mon: 4'd1, date: 5'd1, wday: 3'd1,
               hour: 5'd0, min: 6'd0, sec: 6'd0};
      h12 <= 1'b0;
    end else if (ld_en) begin
      case (ld_idx)
        3'd0: now.sec  <= dec[5:0];
        3'd1: now.min  <= dec[5:0];
        3'd2: begin
          now.hour <= hr_dec;
          h12      <= ld_byte[6];
        end
        3'd3: now.wday <= dec[2:0];
        3'd4: now.date <= dec[4:0];
        3'd5: now.mon  <= dec[3:0];
        3'd6: now.year <= dec;
        default: ;
      endcase
    end else if (tick) begin
      now <= nxt;
    end
  end

  assert_min_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && now.sec == 6'd59 && now.min < 6'd59) |=> (now.sec == 6'd0 && now.min == $past(now.min) + 6'd1));

  assert_leap_day_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_en && now.mon == 4'd2 && now.date == 5'd28 && now.year[1:0] == 2'd0 &&
     now.hour == 5'd23 && now.min == 6'd59 && now.sec == 6'd59) |=> (now.date == 5'd29 && now.mon == 4'd2));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_en) |=> $stable(now));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
#(
  parameter int NREGS = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  rtc_time_t             now,
  input  logic                  h12,
  output logic [NREGS-1:0][7:0] snap
);

  logic [NREGS-1:0][7:0] enc;
  logic [4:0]            hmod;
  logic [7:0]            hbcd;

  always_comb begin
    hmod = (now.hour >= 5'd12) ? now.hour - 5'd12 : now.hour;
    if (hmod == 5'd0) hmod = 5'd12;
    hbcd = bin2bcd({2'b0, hmod});
    enc  = '0;
    enc[0] = bin2bcd({1'b0, now.sec});
    enc[1] = bin2bcd({1'b0, now.min});
    enc[2] = h12 ? {1'b0, 1'b1, (now.hour >= 5'd12), hbcd[4:0]}
                 : bin2bcd({2'b0, now.hour});
    enc[3] = bin2bcd({4'b0, now.wday});
    enc[4] = bin2bcd({2'b0, now.date});
    enc[5] = bin2bcd({3'b0, now.mon});
    enc[6] = bin2bcd(now.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      snap[3] <= 8'h01;
      snap[4] <= 8'h01;
      snap[5] <= 8'h01;
    end else if (capture) begin
      snap <= enc;
    end
  end

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap));

  assert_h12_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (capture && h12) |=> snap[2][6]);

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int TIME_REGS = 7;
  localparam int CTRL_LOC  = 7;
  localparam int RAM_BASE  = 8;

  logic [ADDR_W-1:0]           ptr;
  logic                        data_wr;
  logic                        data_rd;
  logic                        wrap;
  logic                        capture;
  logic                        ld_en;
  rtc_time_t                   now;
  logic                        h12;
  logic [TIME_REGS-1:0][7:0]   snap;

  logic [DATA_W-1:0]           ram [DEPTH];
  logic [DEPTH-1:0]            ram_vld;
  logic [DATA_W-1:0]           ram_q;
  logic                        vld_q;
  logic                        sel_ram_q;
  logic [DATA_W-1:0]           snap_q;

  rtc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_rd(start_rd),
    .wr_valid(wr_valid), .wr_data(wr_data[7:0]), .rd_req(rd_req),
    .ptr(ptr), .data_wr(data_wr), .data_rd(data_rd), .wrap(wrap)
  );

  assign ld_en   = data_wr & (ptr < ADDR_W'(TIME_REGS));
  assign capture = start_wr | start_rd | wrap;

  rtc_timebase u_time (
    .clk(clk), .rst(rst), .tick(tick), .ld_en(ld_en),
    .ld_idx(ptr[2:0]), .ld_byte(wr_data[7:0]), .now(now), .h12(h12)
  );

  rtc_snapshot #(.NREGS(TIME_REGS)) u_snap (
    .clk(clk), .rst(rst), .capture(capture), .now(now), .h12(h12), .snap(snap)
  );

  always_ff @(posedge clk) begin
    if (data_wr && ptr >= ADDR_W'(RAM_BASE)) ram[ptr] <= wr_data;
    ram_q <= ram[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_vld   <= '0;
      vld_q     <= 1'b0;
      sel_ram_q <= 1'b0;
      snap_q    <= '0;
      rd_valid  <= 1'b0;
    end else begin
      if (data_wr && ptr >= ADDR_W'(RAM_BASE)) ram_vld[ptr] <= 1'b1;
      rd_valid <= data_rd;
      if (data_rd) begin
        vld_q     <= ram_vld[ptr];
        sel_ram_q <= (ptr >= ADDR_W'(RAM_BASE));
        snap_q    <= (ptr < ADDR_W'(TIME_REGS)) ? DATA_W'(snap[ptr[2:0]]) : '0;
      end
    end
  end

  assign rd_data = sel_ram_q ? (vld_q ? ram_q : '0) : snap_q;

  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_valid && !start_wr && !start_rd) |=> rd_valid);

  assert_ctrl_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(data_rd) && $past(ptr) == ADDR_W'(CTRL_LOC)) |-> (rd_data == '0));

  assert_wrap_capture_R5: assert property (@(posedge clk) disable iff (rst)
    ((data_wr || data_rd) && ptr == {ADDR_W{1'b1}} && !tick) |=> (snap[0] == bin2bcd({1'b0, now.sec})));

endmodule

// File: tb/tb_rtc_regfile.sv
module tb_rtc_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       start_wr = 1'b0;
  logic       start_rd = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int ms, mm, mh, mw, md, mo, my;
  bit mh12;
  logic [7:0] mram [64];
  logic [7:0] msnap [7];
  int  mptr;
  bit  maddr;

  rtc_regfile dut (
    .clk(clk), .rst(rst), .tick(tick), .start_wr(start_wr), .start_rd(start_rd),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [7:0] enc(input int i);
    int h;
    case (i)
      0: return bcd(ms);
      1: return bcd(mm);
      2: begin
        if (!mh12) return bcd(mh);
        h = mh % 12;
        if (h == 0) h = 12;
        return 8'h40 | (mh >= 12 ? 8'h20 : 8'h00) | bcd(h);
      end
      3: return bcd(mw);
      4: return bcd(md);
      5: return bcd(mo);
      default: return bcd(my);
    endcase
  endfunction

  task automatic model_capture();
    for (int i = 0; i < 7; i++) msnap[i] = enc(i);
  endtask

  task automatic model_adv();
    mptr = (mptr + 1) % 64;
    if (mptr == 0) model_capture();
  endtask

  task automatic model_tick();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw == 7) ? 1 : mw + 1;
          md++;
          if (md > mdays(mo, my)) begin
            md = 1; mo++;
            if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic model_load(input int i, input logic [7:0] b);
    int h;
    case (i)
      0: ms = unbcd(b & 8'h7f);
      1: mm = unbcd(b & 8'h7f);
      2: begin
        mh12 = b[6];
        if (b[6]) begin
          h = unbcd(b & 8'h1f);
          if (h == 12) h = 0;
          if (b[5]) h += 12;
          mh = h;
        end else mh = unbcd(b & 8'h3f);
      end
      3: mw = unbcd(b & 8'h07);
      4: md = unbcd(b & 8'h3f);
      5: mo = unbcd(b & 8'h1f);
      6: my = unbcd(b);
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic go_start_wr();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    maddr = 1'b1;
    model_capture();
  endtask

  task automatic go_start_rd();
    start_rd = 1'b1;
    @(negedge clk);
    start_rd = 1'b0;
    maddr = 1'b0;
    model_capture();
  endtask

  task automatic wbyte(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
    if (maddr) begin
      mptr  = int'(b[5:0]);
      maddr = 1'b0;
    end else begin
      if (mptr < 7) model_load(mptr, b);
      else if (mptr >= 8) mram[mptr] = b;
      model_adv();
    end
  endtask

  task automatic rbyte(input string req);
    logic [7:0] exp;
    if (mptr < 7) exp = msnap[mptr];
    else if (mptr == 7) exp = 8'h00;
    else exp = mram[mptr];
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk({req, " valid"}, {7'd0, rd_valid}, 8'h01);
    chk(req, rd_data, exp);
    model_adv();
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_tick();
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mon, y);
    go_start_wr();
    wbyte(8'h00);
    wbyte(s); wbyte(m); wbyte(h); wbyte(w); wbyte(d); wbyte(mon); wbyte(y);
  endtask

  task automatic read_time(input string req);
    go_start_wr();
    wbyte(8'h00);
    go_start_rd();
    for (int i = 0; i < 7; i++) rbyte(req);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int op;
    void'($urandom(32'h1234));
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0; mh12 = 1'b0;
    for (int i = 0; i < 64; i++) mram[i] = 8'h00;
    mptr = 0; maddr = 1'b0;
    model_capture();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state, R8 cleared RAM, R7 control reads 0
    chk("R11 rd_valid idle", {7'd0, rd_valid}, 8'h00);
    go_start_rd();
    rbyte("R11 sec"); rbyte("R11 min"); rbyte("R11 hour");
    rbyte("R11 wday"); rbyte("R11 date"); rbyte("R11 month"); rbyte("R11 year");
    rbyte("R7 ctrl");
    for (int i = 8; i < 16; i++) rbyte("R8 cleared");

    // R2 pointer masking, R8 RAM storage
    go_start_wr(); wbyte(8'hC8); wbyte(8'hA5); wbyte(8'h5A);
    go_start_wr(); wbyte(8'h08); go_start_rd();
    rbyte("R2 masked ptr"); rbyte("R8 ram");

    // R7 control write ignored
    go_start_wr(); wbyte(8'h07); wbyte(8'hFF);
    go_start_wr(); wbyte(8'h07); go_start_rd();
    rbyte("R7 ctrl ignored");

    // R10 leap day, R6 load
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h04);
    tick1(); read_time("R10 leap feb29");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h04);
    tick1(); read_time("R10 leap mar1");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h03);
    tick1(); read_time("R10 nonleap mar1");
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    tick1(); read_time("R10 year wrap");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    tick1(); read_time("R10 april end");
    // R6 masks: upper bits set are dropped
    set_time(8'hB0, 8'hA5, 8'h10, 8'hFB, 8'hD5, 8'hE7, 8'h21);
    read_time("R6 masked load");

    // R9 12-hour format
    set_time(8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h05, 8'h20);
    read_time("R9 11PM");
    tick1(); read_time("R9 12AM");
    set_time(8'h30, 8'h00, 8'h72, 8'h02, 8'h10, 8'h05, 8'h20);
    read_time("R9 12PM");
    set_time(8'h00, 8'h00, 8'h15, 8'h02, 8'h10, 8'h05, 8'h20);
    read_time("R9 24h");

    // R4 snapshot frozen across ticks
    go_start_wr(); wbyte(8'h00); go_start_rd();
    tick1(); tick1(); tick1();
    rbyte("R4 frozen sec"); rbyte("R4 frozen min");

    // R5 and R1: wrap on write recaptures
    go_start_wr(); wbyte(8'h3F); wbyte(8'h11);
    tick1(); tick1();
    go_start_rd();
    // R5 on read wrap
    go_start_wr(); wbyte(8'h3F); go_start_rd();
    tick1(); tick1();
    rbyte("R1 ram 3F"); rbyte("R5 recapture sec");
    // R5 wrap on write keeps pre-tick capture
    go_start_wr(); wbyte(8'h3F); wbyte(8'h22);
    tick1();
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    chk("R5 write-wrap snapshot", rd_data, msnap[0]);
    model_adv();
    rbyte("R3 next");

    // random mix
    for (int n = 0; n < 400; n++) begin
      op = int'($urandom % 10);
      if (op < 2) tick1();
      else if (op == 2) begin go_start_wr(); wbyte(8'($urandom)); end
      else if (op == 3) go_start_rd();
      else if (op < 6 && mptr >= 7 && !maddr) wbyte(8'($urandom));
      else begin
        if (maddr) go_start_rd();
        rbyte("R3 random");
      end
    end
    b = 8'h00;
    go_start_wr(); wbyte(8'h08); go_start_rd();
    for (int i = 8; i < 64; i++) rbyte("R8 final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule